// File: doc/BRIEF.md
# Conversion Start and Busy Controller

This block runs the conversion cycle of a sampling converter. It counts out an acquisition interval, then decides when to put the sampler into hold and start a conversion, based on a start-conversion input. If start is low when acquisition ends, the conversion starts at once. If start is high then, the block waits for the next falling edge on start. A fixed-latency counter stands in for the conversion engine. When it finishes, the block spends one cycle latching the result, then drops busy and pulses a load strobe to the output port. Acquisition then starts again.

The start input is asynchronous and passes through a two-flop synchronizer before any edge is detected. Two controls act on the cycle. A synchronous abort input (`reset_i`) cancels any conversion in progress and restarts acquisition. A power-down input lets a running conversion finish, then blocks new conversions for as long as it is held high. Acquisition and conversion lengths are parameters counted in clock cycles.

Top module: `conv_start_ctrl`

## Requirements
- R1: While `rst_ni` is low, `busy_o`, `hold_o` and `load_o` are all low.
- R2: If acquisition ends while the synchronized start level is high, no conversion begins until start falls. When `start_i` falls between two clock edges, `busy_o` is first high after the third rising edge that follows.
- R3: If the synchronized start level is low when acquisition ends, the conversion begins with no edge needed. Between two such back-to-back conversions, `busy_o` stays low for exactly ACQ_CYCLES cycles.
- R4: A completed conversion holds `busy_o` high for exactly CONV_CYCLES+1 cycles. `hold_o` rises in the same cycle as `busy_o`, stays high for CONV_CYCLES cycles, and falls one cycle before `busy_o`.
- R5: `load_o` is a one-cycle pulse in the first cycle that `busy_o` is low after a completed conversion. It is never high at any other time.
- R6: A falling edge on `start_i` during acquisition or during a conversion is ignored. If start is back high when acquisition ends, no conversion begins.
- R7: When `pwrdn_i` goes high during a conversion, that conversion still completes with its load pulse. After that, `busy_o` stays low while `pwrdn_i` remains high.
- R8: When `pwrdn_i` is released while the synchronized start level is low, a conversion begins on the next clock edge. `busy_o` is high in the cycle after the one in which the release was sampled.
- R9: A one-cycle high on `reset_i` drives `busy_o` and `hold_o` low on the next cycle with no load pulse, even in the final latch cycle. A fresh acquisition of ACQ_CYCLES cycles then follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Asynchronous start-conversion request |
| reset_i | input | 1 | Synchronous abort, active high |
| pwrdn_i | input | 1 | Power-down, blocks new conversions |
| busy_o | output | 1 | High from conversion start until the result is latched |
| hold_o | output | 1 | Sampler hold control, high while converting |
| load_o | output | 1 | One-cycle strobe that transfers the result to the output port |

## Verification
Two pairs of functions can meet in the same cycle.

The first pair is the abort and the latch that completes a conversion. The bench raises `reset_i` in exactly the cycle where `hold_o` has fallen but `busy_o` is still high. It then judges that `busy_o` falls on the usual cycle but `load_o` stays low, and that the next acquisition is counted from that abort.

The second pair is a falling start edge and the acquisition timer. The bench drops start during acquisition and during conversion, and restores it before acquisition ends. It then expects no conversion at all. A scoreboard of expected busy edges, with their cycle numbers and load values, judges every transition.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic [2:0] {
    ST_ACQ   = 3'd0,
    ST_ARM   = 3'd1,
    ST_PDN   = 3'd2,
    ST_CONV  = 3'd3,
    ST_LATCH = 3'd4
  } cs_state_e;
endpackage

// File: rtl/cs_start_sync.sv
module cs_start_sync #(
  parameter int unsigned STAGES   = 2,
  parameter bit          IDLE_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= {(STAGES+1){IDLE_VAL}};
    else         sh_q <= {sh_q[STAGES-1:0], start_i};
  end

  assign level_o = sh_q[STAGES-1];
  // one extra stage gives the previous level for edge detection
  assign fall_o  = sh_q[STAGES] & ~sh_q[STAGES-1];

  a_r2_fall_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/cs_interval_timer.sv
module cs_interval_timer #(
  parameter int unsigned LEN      = 8,
  parameter bit          BOOT_RUN = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic clr_i,
  output logic expired_o
);
  localparam int unsigned CW   = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= LAST;
      run_q <= BOOT_RUN;
    end else if (clr_i) begin
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= LAST;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = run_q && (cnt_q == '0);

  a_r3_timer_keeps_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !expired_o && !clr_i) |=> run_q);
  a_r4_timer_expiry_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !load_i) |=> !expired_o);
endmodule

// File: rtl/conv_start_ctrl.sv
module conv_start_ctrl
  import cs_pkg::*;
#(
  parameter int unsigned ACQ_CYCLES  = 8,
  parameter int unsigned CONV_CYCLES = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic reset_i,
  input  logic pwrdn_i,
  output logic busy_o,
  output logic hold_o,
  output logic load_o
);
  cs_state_e st_q, st_d;
  logic start_lvl, start_fall;
  logic acq_exp, conv_exp;
  logic acq_load, conv_load;
  logic load_q;

  cs_start_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .level_o (start_lvl),
    .fall_o  (start_fall)
  );

  // acquisition interval, armed out of reset
  cs_interval_timer #(.LEN(ACQ_CYCLES), .BOOT_RUN(1'b1)) u_acq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (acq_load),
    .clr_i     (1'b0),
    .expired_o (acq_exp)
  );

  // fixed-latency conversion stand-in
  cs_interval_timer #(.LEN(CONV_CYCLES), .BOOT_RUN(1'b0)) u_conv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (conv_load),
    .clr_i     (reset_i),
    .expired_o (conv_exp)
  );

  always_comb begin
    st_d = st_q;
    if (reset_i) begin
      st_d = ST_ACQ;
    end else begin
      unique case (st_q)
        ST_ACQ: if (acq_exp) begin
          if (pwrdn_i)         st_d = ST_PDN;
          else if (!start_lvl) st_d = ST_CONV;
          else                 st_d = ST_ARM;
        end
        ST_ARM: begin
          if (pwrdn_i)         st_d = ST_PDN;
          else if (start_fall) st_d = ST_CONV;
        end
        ST_PDN:   if (!pwrdn_i) st_d = start_lvl ? ST_ARM : ST_CONV;
        ST_CONV:  if (conv_exp) st_d = ST_LATCH;
        ST_LATCH: st_d = ST_ACQ;
        default:  st_d = ST_ACQ;
      endcase
    end
  end

  assign acq_load  = reset_i || (st_d == ST_ACQ && st_q != ST_ACQ);
  assign conv_load = !reset_i && (st_d == ST_CONV) && (st_q != ST_CONV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_ACQ;
      load_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      load_q <= (st_q == ST_LATCH) && !reset_i;
    end
  end

  assign busy_o = (st_q == ST_CONV) || (st_q == ST_LATCH);
  assign hold_o = (st_q == ST_CONV);
  assign load_o = load_q;

  a_r4_hold_rises_with_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> hold_o);
  a_r4_busy_outlasts_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(hold_o) && !$past(reset_i)) |-> busy_o);
  a_r5_load_on_busy_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> $fell(busy_o));
  a_r7_pwrdn_blocks_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwrdn_i && !busy_o) |=> !busy_o);
  a_r9_abort_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_i |=> (!busy_o && !hold_o && !load_o));
endmodule

// File: tb/sim_conv_start_ctrl.sv
module sim_conv_start_ctrl;
  localparam int A = 8;
  localparam int C = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b1, reset_i = 1'b0, pwrdn_i = 1'b0;
  logic busy_o, hold_o, load_o;

  always #5 clk = ~clk;

  conv_start_ctrl #(.ACQ_CYCLES(A), .CONV_CYCLES(C), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .reset_i(reset_i),
    .pwrdn_i(pwrdn_i), .busy_o(busy_o), .hold_o(hold_o), .load_o(load_o)
  );

  typedef struct {
    bit    rise;
    int    cyc;
    bit    ld;
    string req;
  } ev_t;

  ev_t exp_q[$];
  int  cyc = 0;
  int  n_vec = 0, n_bad = 0;
  bit  done = 1'b0;
  logic prev_busy = 1'b0, prev_hold = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic push(input bit rise, input int c, input bit ld, input string req);
    ev_t e;
    e.rise = rise; e.cyc = c; e.ld = ld; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  // monitor: every busy transition is compared with the scoreboard head
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (busy_o !== prev_busy) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected busy edge", cyc, -1);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          chk(busy_o == e.rise, e.req, busy_o, e.rise);
          chk(cyc == e.cyc, e.req, cyc, e.cyc);
          if (e.rise) begin
            chk(hold_o == 1'b1, "R4 hold with busy rise", hold_o, 1);
          end else begin
            chk(load_o == e.ld, "R5 load at busy fall", load_o, e.ld);
            chk(hold_o == 1'b0, "R4 hold low at busy fall", hold_o, 0);
            if (e.ld) chk(prev_hold == 1'b0, "R4 hold falls one cycle early", prev_hold, 0);
          end
        end
      end else if (load_o) begin
        chk(1'b0, "R5 stray load pulse", load_o, 0);
      end
      if (hold_o && !busy_o) chk(1'b0, "R4 hold without busy", hold_o, 0);
      prev_busy = busy_o;
      prev_hold = hold_o;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int k, f, f2, p, p2, r, r2;
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R1 busy in reset", busy_o, 0);
    chk(hold_o == 1'b0, "R1 hold in reset", hold_o, 0);
    chk(load_o == 1'b0, "R1 load in reset", load_o, 0);
    rst_ni = 1'b1;

    // armed: acquisition ends with start high, nothing happens
    repeat (3 * A) @(negedge clk);
    chk(busy_o == 1'b0, "R2 waits for start edge", busy_o, 0);

    // armed start, then immediate back-to-back conversion
    k = cyc; start_i = 1'b0;
    push(1'b1, k + 3, 1'b0, "R2 busy after start fall");
    push(1'b0, k + 4 + C, 1'b1, "R4 busy length");
    f = k + 4 + C;
    push(1'b1, f + A, 1'b0, "R3 immediate start after acquisition");
    f2 = f + A + C + 1;
    push(1'b0, f2, 1'b1, "R3 busy length immediate");
    wait_cyc(f + A + 2); start_i = 1'b1;
    drain();

    // start edge during acquisition is ignored
    wait_cyc(f2 + 1); start_i = 1'b0;
    @(negedge clk);   start_i = 1'b1;
    wait_cyc(f2 + A + 20);
    chk(busy_o == 1'b0, "R6 edge in acquisition ignored", busy_o, 0);

    // start edge during conversion is ignored
    k = cyc; start_i = 1'b0;
    push(1'b1, k + 3, 1'b0, "R2 armed start");
    push(1'b0, k + 4 + C, 1'b1, "R4 busy length");
    wait_cyc(k + 5); start_i = 1'b1;
    wait_cyc(k + 6); start_i = 1'b0;
    wait_cyc(k + 7); start_i = 1'b1;
    drain();
    repeat (A + 20) @(negedge clk);
    chk(busy_o == 1'b0, "R6 edge in conversion ignored", busy_o, 0);

    // power-down during a conversion
    k = cyc; start_i = 1'b0;
    push(1'b1, k + 3, 1'b0, "R2 armed start");
    push(1'b0, k + 4 + C, 1'b1, "R7 conversion completes under power-down");
    wait_cyc(k + 5); pwrdn_i = 1'b1;
    drain();
    repeat (3 * (A + C)) @(negedge clk);
    chk(busy_o == 1'b0, "R7 no conversion while powered down", busy_o, 0);

    // release with start low: conversion on next edge
    p = cyc; pwrdn_i = 1'b0;
    push(1'b1, p + 1, 1'b0, "R8 start on power-down release");
    push(1'b0, p + 2 + C, 1'b1, "R4 busy length");
    wait_cyc(p + 3); pwrdn_i = 1'b1;
    drain();
    repeat (A + 10) @(negedge clk);
    chk(busy_o == 1'b0, "R7 blocked again", busy_o, 0);

    // abort mid-conversion, then abort coinciding with the latch cycle
    p2 = cyc; pwrdn_i = 1'b0;
    push(1'b1, p2 + 1, 1'b0, "R8 start on power-down release");
    push(1'b0, p2 + 5, 1'b0, "R9 abort mid-conversion");
    r = p2 + 5 + A;
    push(1'b1, r, 1'b0, "R9 acquisition restarts after abort");
    push(1'b0, r + C + 1, 1'b0, "R9 abort in latch cycle drops load");
    r2 = r + C + 1 + A;
    push(1'b1, r2, 1'b0, "R9 acquisition after latch abort");
    push(1'b0, r2 + C + 1, 1'b1, "R5 normal load after aborts");
    wait_cyc(p2 + 4); reset_i = 1'b1;
    @(negedge clk);   reset_i = 1'b0;
    wait_cyc(r + C);  reset_i = 1'b1;
    @(negedge clk);   reset_i = 1'b0;
    wait_cyc(r2 + 1); start_i = 1'b1;
    drain();
    repeat (A + 10) @(negedge clk);
    chk(busy_o == 1'b0, "R2 idle armed at end", busy_o, 0);
    chk(exp_q.size() == 0, "R5 scoreboard empty", exp_q.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule